// File: doc/BRIEF.md
# Event Timer Main Counter and Register File

This block is the shared front end of a multi-channel event timer. It holds the 64-bit main up-counter, the global configuration (a run bit and a legacy-route bit) and a read-only capability word. It also decodes the per-channel register windows for the timer channels that sit beside it. A 32-bit register bus reads and writes every 64-bit quantity as two 32-bit halves. The counter advances by one on each `tick_en` pulse from an external prescaler, but only while the block is running.

The run bit drives a four-state controller. **ST_HALTED** holds the counter still, and the counter can then be written. The transition *start* (run bit seen at 1) leads to **ST_ARM**. That state lasts one cycle: it counts and raises `arm_all`, which tells every channel to re-arm. A channel re-arms only if its comparator is not all ones, and the channel makes that check itself. The transition *settle* (run bit still 1) then leads to **ST_RUNNING**, where counting goes on. The transition *stop* (run bit seen at 0, from ST_ARM or ST_RUNNING) leads to **ST_HALT**. That state also lasts one cycle: the counter is already held and `halt_all` is raised. From ST_HALT, the transition *rest* leads to ST_HALTED. If the run bit is back at 1, the transition *restart* leads to ST_ARM instead.

The channel windows begin at byte 0x100 and each is 0x20 bytes long. The block does not store channel registers. It gives a write strobe per channel, the word offset and the channel index, and it returns the read data that the channel supplies.

Top module: `evt_regblk`

## Requirements
- R1: Byte 0x000 reads the capability low word: bits 7:0 = 0x01, bits 12:8 = (effective timer count − 1), bit 13 = 1, bit 14 = 0, bit 15 = 1, bits 31:16 = 0x8086 (0x8086A201 with 3 timers). Byte 0x004 reads the tick period in femtoseconds (`PERIOD_FS`). Writes to both words are ignored. The effective timer count is `NUM_TIMERS` clamped to the range 3..32.
- R2: A write to the configuration word (byte 0x010) updates only bits 1:0, where bit 0 is run and bit 1 is legacy route. All other bits read 0. The upper configuration word (byte 0x014) reads 0, and writes to it are ignored.
- R3: While running (ST_ARM or ST_RUNNING), the counter rises by exactly 1 at each clock edge where `tick_en` is 1, with carry across the 32-bit halves. While halted (ST_HALTED or ST_HALT), the counter holds.
- R4: The counter halves at bytes 0x0F0 (low) and 0x0F4 (high) can be written while halted. Writes to them while running are ignored.
- R5: A read of the counter halves returns the live counter while running and the frozen value while halted. After reset, the counter reads 0.
- R6: A write that sets the run bit from 0 to 1 raises `arm_all` for exactly one cycle, starting the cycle after the write edge. Counting resumes from the stored value.
- R7: A write that clears the run bit from 1 to 0 raises `halt_all` for exactly one cycle, starting the cycle after the write edge. The counter keeps the value it held at that point.
- R8: A write to channel n (byte 0x100 + 0x20·n) at word offset 0 (0x00), 2, 3, 4 or 5 raises only `tmr_wr_stb[n]` during the access. Offset 1 (0x04, channel capability) and offsets 6 and 7 raise no strobe.
- R9: A channel index at or above the effective timer count raises no strobe and reads 0.
- R10: Read data appears on `bus_rdata` from the clock edge that samples the read. For channel addresses, it is the `tmr_rdata` selected by `tmr_idx` and `tmr_off`.
- R11: `cfg_legacy` and `cfg_enable` follow configuration bits 1 and 0.
- R12: Unmapped global addresses and addresses that are not 32-bit aligned read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick pulse |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cnt_value | output | 64 | Main counter to the channels |
| cfg_enable | output | 1 | Run bit |
| cfg_legacy | output | 1 | Legacy-route bit |
| arm_all | output | 1 | One-cycle re-arm request to all channels |
| halt_all | output | 1 | One-cycle halt request to all channels |
| tmr_wr_stb | output | 32 | Per-channel write strobe |
| tmr_idx | output | 5 | Channel index of the current address |
| tmr_off | output | 3 | Word offset within the channel window |
| tmr_rdata | input | 32 | Read data from the selected channel |

## Verification
The hardest case to reach is a counter value that carries from the low half into the high half while the counter is running. Reaching it by counting from reset would take 2^32 ticks. The bench instead loads 0x1_FFFFFFFE into both halves while the block is halted, sets the run bit and holds `tick_en` for five cycles. It then expects 0x2_00000003, which exercises the arm pulse and the resume-from-stored-value path in the same sequence. The same preloaded value is then used to show that writes while running are dropped and that a stop followed by a restart keeps the count.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W      = 10;
    localparam int MAX_TIMERS  = 32;
    localparam int MIN_TIMERS  = 3;
    localparam int CFG_BITS    = 2;

    localparam logic [ADDR_W-1:0] A_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] A_CFG_LO = 10'h010;
    localparam logic [ADDR_W-1:0] A_CFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_ARM     = 2'd1,
        ST_RUNNING = 2'd2,
        ST_HALT    = 2'd3
    } run_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP_LO,
        SEL_CAP_HI,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_TMR
    } reg_sel_e;

    function automatic logic [31:0] cap_low_word(input int nt);
        logic [4:0] cnt_field;
        cnt_field = 5'(nt - 1);
        return {16'h8086, 1'b1, 1'b0, 1'b1, cnt_field, 8'h01};
    endfunction

endpackage

// File: rtl/evt_run_ctl.sv
module evt_run_ctl
    import evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_bit,
    output run_state_e state_q,
    output logic       counting,
    output logic       arm_pulse,
    output logic       halt_pulse
);

    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  state_d = run_bit ? ST_ARM : ST_HALTED;
            ST_ARM:     state_d = run_bit ? ST_RUNNING : ST_HALT;
            ST_RUNNING: state_d = run_bit ? ST_RUNNING : ST_HALT;
            ST_HALT:    state_d = run_bit ? ST_ARM : ST_HALTED;
        endcase
    end

    always_comb begin
        counting   = 1'b0;
        arm_pulse  = 1'b0;
        halt_pulse = 1'b0;
        unique case (state_q)
            ST_HALTED:  ;
            ST_ARM:     begin counting = 1'b1; arm_pulse = 1'b1; end
            ST_RUNNING: counting = 1'b1;
            ST_HALT:    halt_pulse = 1'b1;
        endcase
    end

endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load_lo,
    input  logic             load_hi,
    input  logic [31:0]      load_val,
    output logic [CNT_W-1:0] value
);

    localparam int HI_W = CNT_W - 32;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= value + CNT_W'(1);
        end else if (load_lo) begin
            value[31:0] <= load_val;
        end else if (load_hi) begin
            value[CNT_W-1:32] <= load_val[HI_W-1:0];
        end
    end

endmodule

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_pkg::*;
#(
    parameter int NT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [4:0]        tidx,
    output logic [2:0]        woff,
    output logic              tmr_ok
);

    logic in_tmr_space;
    logic aligned;

    assign aligned      = (addr[1:0] == 2'b00);
    assign in_tmr_space = (addr[ADDR_W-1:8] != '0);
    assign tidx         = addr[9:5] - 5'd8;
    assign woff         = addr[4:2];
    assign tmr_ok       = aligned && in_tmr_space && (int'(tidx) < NT);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (in_tmr_space) begin
                sel = SEL_TMR;
            end else begin
                unique case (addr)
                    A_CAP_LO: sel = SEL_CAP_LO;
                    A_CAP_HI: sel = SEL_CAP_HI;
                    A_CFG_LO: sel = SEL_CFG_LO;
                    A_CFG_HI: sel = SEL_CFG_HI;
                    A_CNT_LO: sel = SEL_CNT_LO;
                    A_CNT_HI: sel = SEL_CNT_HI;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_regblk.sv
module evt_regblk
    import evt_pkg::*;
#(
    parameter int          NUM_TIMERS = 3,
    parameter logic [31:0] PERIOD_FS  = 32'd10_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [63:0]           cnt_value,
    output logic                  cfg_enable,
    output logic                  cfg_legacy,
    output logic                  arm_all,
    output logic                  halt_all,
    output logic [MAX_TIMERS-1:0] tmr_wr_stb,
    output logic [4:0]            tmr_idx,
    output logic [2:0]            tmr_off,
    input  logic [31:0]           tmr_rdata
);

    localparam int NT_EFF = (NUM_TIMERS < MIN_TIMERS) ? MIN_TIMERS :
                            (NUM_TIMERS > MAX_TIMERS) ? MAX_TIMERS : NUM_TIMERS;
    localparam logic [31:0] CFG_MASK = 32'((1 << CFG_BITS) - 1);
    localparam logic [31:0] CAP_LO   = cap_low_word(NT_EFF);

    reg_sel_e      sel;
    logic          tmr_ok;
    logic          wr_acc;
    logic          rd_acc;
    logic [31:0]   cfg_q;
    run_state_e    state_q;
    logic          counting;
    logic          frozen;
    logic          tmr_wr;

    assign wr_acc = bus_valid && bus_write;
    assign rd_acc = bus_valid && !bus_write;

    evt_addr_dec #(.NT(NT_EFF)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .tidx   (tmr_idx),
        .woff   (tmr_off),
        .tmr_ok (tmr_ok)
    );

    evt_run_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_bit    (cfg_q[0]),
        .state_q    (state_q),
        .counting   (counting),
        .arm_pulse  (arm_all),
        .halt_pulse (halt_all)
    );

    assign frozen = !counting;

    evt_main_cnt #(.CNT_W(64)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (counting && tick_en),
        .load_lo  (frozen && wr_acc && sel == SEL_CNT_LO),
        .load_hi  (frozen && wr_acc && sel == SEL_CNT_HI),
        .load_val (bus_wdata),
        .value    (cnt_value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_acc && sel == SEL_CFG_LO) begin
            cfg_q <= (cfg_q & ~CFG_MASK) | (bus_wdata & CFG_MASK);
        end
    end

    assign cfg_enable = cfg_q[0];
    assign cfg_legacy = cfg_q[1];

    assign tmr_wr = wr_acc && tmr_ok && (tmr_off != 3'd1) && (tmr_off < 3'd6);

    for (genvar g = 0; g < MAX_TIMERS; g++) begin : g_stb
        if (g < NT_EFF) begin : g_live
            assign tmr_wr_stb[g] = tmr_wr && (tmr_idx == 5'(g));
        end else begin : g_absent
            assign tmr_wr_stb[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_acc) begin
            unique case (sel)
                SEL_CAP_LO: bus_rdata <= CAP_LO;
                SEL_CAP_HI: bus_rdata <= PERIOD_FS;
                SEL_CFG_LO: bus_rdata <= cfg_q;
                SEL_CNT_LO: bus_rdata <= cnt_value[31:0];
                SEL_CNT_HI: bus_rdata <= cnt_value[63:32];
                SEL_TMR:    bus_rdata <= tmr_ok ? tmr_rdata : 32'd0;
                SEL_CFG_HI,
                SEL_NONE:   bus_rdata <= 32'd0;
            endcase
        end
    end

endmodule

// File: rtl/evt_regblk_chk.sv
module evt_regblk_chk
    import evt_pkg::*;
#(
    parameter int NT_EFF = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_en,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [63:0]           cnt_value,
    input logic                  cfg_enable,
    input logic                  arm_all,
    input logic                  halt_all,
    input logic [MAX_TIMERS-1:0] tmr_wr_stb,
    input run_state_e            state_q
);

    logic held;
    logic cnt_wr;

    assign held   = (state_q == ST_HALTED) || (state_q == ST_HALT);
    assign cnt_wr = bus_valid && bus_write &&
                    (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cnt_wr) |=> $stable(cnt_value)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && tick_en) |=> (cnt_value == $past(cnt_value) + 64'd1)); // R3

    AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !tick_en) |=> $stable(cnt_value)); // R4

    AST_ARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_all |=> !arm_all); // R6

    AST_ARM_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_all) |-> $past(cfg_enable)); // R6

    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_all |=> !halt_all); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_wr_stb)); // R8

    AST_NO_ABSENT_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_wr_stb >> NT_EFF) == '0)); // R9

endmodule

bind evt_regblk evt_regblk_chk #(.NT_EFF(NT_EFF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .cnt_value  (cnt_value),
    .cfg_enable (cfg_enable),
    .arm_all    (arm_all),
    .halt_all   (halt_all),
    .tmr_wr_stb (tmr_wr_stb),
    .state_q    (state_q)
);

// File: tb/evt_regblk_tb.sv
module evt_regblk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] cnt_value;
    logic        cfg_enable, cfg_legacy, arm_all, halt_all;
    logic [31:0] tmr_wr_stb;
    logic [4:0]  tmr_idx;
    logic [2:0]  tmr_off;
    logic [31:0] tmr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign tmr_rdata = {16'hC0DE, 3'b0, tmr_idx, 5'b0, tmr_off};

    evt_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
        .cfg_enable(cfg_enable), .cfg_legacy(cfg_legacy),
        .arm_all(arm_all), .halt_all(halt_all), .tmr_wr_stb(tmr_wr_stb),
        .tmr_idx(tmr_idx), .tmr_off(tmr_off), .tmr_rdata(tmr_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, output logic [31:0] stb);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        #1 stb = tmr_wr_stb;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R5 counter after reset", cnt_value, 64'd0);
        check("R6 arm idle", {63'd0, arm_all}, 64'd0);
        rd(10'h000, d); check("R1 cap low", {32'd0, d}, 64'h8086A201);
        rd(10'h004, d); check("R1 cap high", {32'd0, d}, 64'd10_000_000);
        rd(10'h010, d); check("R2 cfg reset", {32'd0, d}, 64'd0);
    endtask

    task automatic t_cap_cfg;
        logic [31:0] d, s;
        wr(10'h000, 32'hFFFF_FFFF, s);
        rd(10'h000, d); check("R1 cap write ignored", {32'd0, d}, 64'h8086A201);
        wr(10'h010, 32'hFFFF_FFFE, s);
        rd(10'h010, d); check("R2 cfg masked", {32'd0, d}, 64'h2);
        check("R11 legacy out", {62'd0, cfg_legacy, cfg_enable}, 64'h2);
        wr(10'h014, 32'hFFFF_FFFF, s);
        rd(10'h014, d); check("R2 cfg high zero", {32'd0, d}, 64'd0);
        wr(10'h010, 32'h0, s);
        check("R11 legacy cleared", {63'd0, cfg_legacy}, 64'd0);
    endtask

    task automatic t_counter;
        logic [31:0] d, s;
        wr(10'h0F0, 32'hFFFF_FFFE, s);
        wr(10'h0F4, 32'h0000_0001, s);
        check("R4 halted load", cnt_value, 64'h1_FFFF_FFFE);
        ticks(4);
        check("R3 holds while halted", cnt_value, 64'h1_FFFF_FFFE);
        wr(10'h010, 32'h1, s);
        check("R6 no arm yet", {63'd0, arm_all}, 64'd0);
        @(negedge clk);
        check("R6 arm pulse", {63'd0, arm_all}, 64'd1);
        @(negedge clk);
        check("R6 arm ends", {63'd0, arm_all}, 64'd0);
        ticks(5);
        check("R3 carry count", cnt_value, 64'h2_0000_0003);
        rd(10'h0F0, d); check("R5 live low", {32'd0, d}, 64'h3);
        rd(10'h0F4, d); check("R5 live high", {32'd0, d}, 64'h2);
        wr(10'h0F0, 32'h0, s);
        check("R4 running write ignored", cnt_value, 64'h2_0000_0003);
        wr(10'h010, 32'h0, s);
        @(negedge clk);
        check("R7 halt pulse", {63'd0, halt_all}, 64'd1);
        @(negedge clk);
        check("R7 halt ends", {63'd0, halt_all}, 64'd0);
        ticks(3);
        check("R7 frozen", cnt_value, 64'h2_0000_0003);
        rd(10'h0F0, d); check("R5 frozen low", {32'd0, d}, 64'h3);
        wr(10'h010, 32'h1, s);
        repeat (2) @(negedge clk);
        ticks(2);
        check("R6 resume from stored", cnt_value, 64'h2_0000_0005);
        wr(10'h010, 32'h0, s);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_windows;
        logic [31:0] d, s;
        wr(10'h128, 32'h55, s); check("R8 ch1 cmp strobe", {32'd0, s}, 64'h2);
        wr(10'h100, 32'h55, s); check("R8 ch0 cfg strobe", {32'd0, s}, 64'h1);
        wr(10'h154, 32'h55, s); check("R8 ch2 route hi strobe", {32'd0, s}, 64'h4);
        wr(10'h124, 32'h55, s); check("R8 cap hi no strobe", {32'd0, s}, 64'h0);
        wr(10'h118, 32'h55, s); check("R8 reserved no strobe", {32'd0, s}, 64'h0);
        wr(10'h160, 32'h55, s); check("R9 absent ch no strobe", {32'd0, s}, 64'h0);
        rd(10'h168, d); check("R9 absent ch reads 0", {32'd0, d}, 64'h0);
        rd(10'h148, d); check("R10 ch2 read", {32'd0, d}, 64'hC0DE_0202);
    endtask

    task automatic t_unmapped;
        logic [31:0] d, s;
        wr(10'h020, 32'hFFFF_FFFF, s);
        wr(10'h0F1, 32'h0, s);
        rd(10'h020, d); check("R12 unmapped reads 0", {32'd0, d}, 64'h0);
        rd(10'h011, d); check("R12 unaligned reads 0", {32'd0, d}, 64'h0);
        check("R12 counter untouched", cnt_value, 64'h2_0000_0005);
        rd(10'h010, d); check("R12 cfg untouched", {32'd0, d}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_cap_cfg;
        t_counter;
        t_windows;
        t_unmapped;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule